// File: doc/BRIEF.md
# Block Transform Load/Unload Sequencer

This block is the control state machine that surrounds a block-oriented transform engine such as a large-point FFT. A block-start pulse marks the first complex sample of a block. The sequencer then takes one sample on each following clock in natural order and writes it to the engine's input storage through a simple write port. While it does this it drives a loading flag and a busy flag. The transform datapath is not part of this block. Its processing time is modelled as a fixed count of cycles after the last sample is taken. That count is a multiple of the block length N.

When the modelled processing ends, the sequencer raises a result-ready flag. A download starts when the user asserts the output enable while the result is ready. The sequencer then issues N read addresses in natural order to a result memory whose read latency is fixed. It delays the output-valid and output-first strobes so that they line up with the returning data. If the download ends and no new block has been started since the result was produced, the result is offered again so it can be read out another time. This supports schemes that repeat part of a block, such as cyclic-prefix insertion.

The block length is selected by a size code that is captured during a synchronous clear. The same clear also captures a forward/inverse flag, which is passed on to the datapath. An asynchronous active-low reset selects the smallest size in forward mode.

Top module: `xfer_ctrl`

## Requirements
- R1: After a block start is accepted, `loading` is high for exactly N-1 cycles. Sample i (i = 0..N-1) is written with `wr_addr` = i, in order, one sample per cycle, and sample 0 is written on the cycle after the start is taken.
- R2: `in_start` has no effect while `busy` is high. No write occurs, and the loading and busy timing of the current block does not change.
- R3: `busy` rises on the cycle after an accepted start and stays high for 4N-1 cycles. This covers N-1 load cycles plus 3N processing cycles. N is 2^LOG2_MIN, 2^(LOG2_MIN+1) or 2^(LOG2_MIN+2) for size codes 01, 10 and 11.
- R4: `res_ready` rises on the same cycle that `busy` falls. It is low on the cycle after an enable is accepted.
- R5: Output data follows the enable cycle by two cycles. When `out_en` is high in cycle k with `res_ready` high, `rd_en` is high from cycle k+1 for N cycles with `rd_addr` = 0..N-1. `out_valid` is high from cycle k+2 for N cycles, and `out_first` is high only with the first of them.
- R6: If `out_en` is held high, a download starts on the cycle after `res_ready` rises, with no other action needed.
- R7: When a download's reads end and no block has started since the result was produced, `res_ready` rises again on the cycle `rd_en` falls. If a block has started, `res_ready` stays low.
- R8: While `clr` is high at a clock edge, the sequencer returns to idle and captures `cfg_size` and `cfg_inv`, shown on `xf_size` and `xf_inv`. The asynchronous reset gives idle with `xf_size` = 01 and `xf_inv` = 0.
- R9: Size code 00 is stored as 01 and runs as the smallest N.
- R10: An `out_en` that arrives before `res_ready` is high starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear and configuration capture |
| cfg_size | input | 2 | Size code captured during clear |
| cfg_inv | input | 1 | Inverse-transform flag captured during clear |
| in_start | input | 1 | Block start, marks sample 0 |
| in_re | input | DATA_W | Input sample, real part |
| in_im | input | DATA_W | Input sample, imaginary part |
| out_en | input | 1 | Download enable |
| loading | output | 1 | Block load in progress |
| busy | output | 1 | Loading or processing; new starts ignored |
| res_ready | output | 1 | Result available for download |
| wr_en | output | 1 | Input storage write strobe |
| wr_addr | output | ADDR_W | Input storage write address |
| wr_re | output | DATA_W | Write data, real part |
| wr_im | output | DATA_W | Write data, imaginary part |
| rd_en | output | 1 | Result memory read strobe |
| rd_addr | output | ADDR_W | Result memory read address |
| out_valid | output | 1 | Output sample valid, aligned to read data |
| out_first | output | 1 | Marks output sample 0 |
| xf_size | output | 2 | Active size code |
| xf_inv | output | 1 | Active inverse flag |

## Verification
The bench builds the sequencer with LOG2_MIN = 4, PROC_MULT = 3 and RD_LAT = 1, so the three sizes are 16, 32 and 64 samples. With these values a full load, process and download of every size, the repeated readout and the held-enable mode all run within a few thousand cycles. The exact 4N-1 busy window and the two-cycle enable latency are still measured cycle by cycle. The reserved size code and a clear in the middle of a load are covered with the same short blocks.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_PROC = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [1:0] size;
        logic       inv;
    } cfg_regs_t;

endpackage

// File: rtl/xfer_load.sv
module xfer_load #(
    parameter int ADDR_W = 13,
    parameter int PCNT_W = 15,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] re_i,
    input  logic [DATA_W-1:0] im_i,
    input  logic [ADDR_W-1:0] n_last_i,
    input  logic [PCNT_W-1:0] p_last_i,
    output logic              loading_o,
    output logic              busy_o,
    output logic              accept_o,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_re_o,
    output logic [DATA_W-1:0] wr_im_o
);
    import xfer_pkg::*;

    typedef struct packed {
        ld_state_e         st;
        logic [ADDR_W-1:0] cnt;
        logic [PCNT_W-1:0] pcnt;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_re;
        logic [DATA_W-1:0] wr_im;
    } ld_regs_t;

    ld_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        unique case (r_q.st)
            LD_IDLE: begin
                if (start_i) begin
                    r_d.st      = LD_FILL;
                    r_d.cnt     = ADDR_W'(1);
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = '0;
                    r_d.wr_re   = re_i;
                    r_d.wr_im   = im_i;
                end
            end
            LD_FILL: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = r_q.cnt;
                r_d.wr_re   = re_i;
                r_d.wr_im   = im_i;
                if (r_q.cnt == n_last_i) begin
                    r_d.st   = LD_PROC;
                    r_d.pcnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            LD_PROC: begin
                if (r_q.pcnt == p_last_i) begin
                    r_d.st = LD_IDLE;
                end else begin
                    r_d.pcnt = r_q.pcnt + 1'b1;
                end
            end
            default: r_d.st = LD_IDLE;
        endcase
        if (clr_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign accept_o  = (r_q.st == LD_IDLE) && start_i && !clr_i;
    assign done_o    = (r_q.st == LD_PROC) && (r_q.pcnt == p_last_i) && !clr_i;
    assign loading_o = (r_q.st == LD_FILL);
    assign busy_o    = (r_q.st != LD_IDLE);
    assign wr_en_o   = r_q.wr_en;
    assign wr_addr_o = r_q.wr_addr;
    assign wr_re_o   = r_q.wr_re;
    assign wr_im_o   = r_q.wr_im;

endmodule

// File: rtl/xfer_drain.sv
module xfer_drain #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              done_i,
    input  logic              blk_i,
    input  logic [ADDR_W-1:0] n_last_i,
    output logic              ready_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_first_o
);
    typedef struct packed {
        logic              ready;
        logic              active;
        logic [ADDR_W-1:0] cnt;
        logic              fresh;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic     take_d;
    logic     last_d;

    always_comb begin
        r_d    = r_q;
        take_d = r_q.ready && en_i && !r_q.active;
        last_d = r_q.active && (r_q.cnt == n_last_i);

        // a newer block makes the held result stale for re-offering
        if (blk_i) begin
            r_d.fresh = 1'b1;
        end else if (done_i) begin
            r_d.fresh = 1'b0;
        end

        if (take_d) begin
            r_d.active = 1'b1;
            r_d.cnt    = '0;
        end else if (last_d) begin
            r_d.active = 1'b0;
        end else if (r_q.active) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end

        if (take_d) begin
            r_d.ready = 1'b0;
        end else if (done_i) begin
            r_d.ready = 1'b1;
        end else if (last_d && !r_d.fresh) begin
            r_d.ready = 1'b1;
        end

        if (clr_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o    = r_q.ready;
    assign rd_en_o    = r_q.active;
    assign rd_addr_o  = r_q.cnt;
    assign rd_first_o = r_q.active && (r_q.cnt == '0);

endmodule

// File: rtl/xfer_pipe.sv
module xfer_pipe #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic vld_i,
    input  logic fst_i,
    output logic vld_o,
    output logic fst_o
);
    generate
        if (LAT == 0) begin : g_thru
            assign vld_o = vld_i;
            assign fst_o = fst_i;
        end else begin : g_dly
            logic [LAT-1:0] vld_d, vld_q;
            logic [LAT-1:0] fst_d, fst_q;

            always_comb begin
                vld_d[0] = vld_i;
                fst_d[0] = fst_i;
                for (int k = 1; k < LAT; k++) begin
                    vld_d[k] = vld_q[k-1];
                    fst_d[k] = fst_q[k-1];
                end
                if (clr_i) begin
                    vld_d = '0;
                    fst_d = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    fst_q <= '0;
                end else begin
                    vld_q <= vld_d;
                    fst_q <= fst_d;
                end
            end

            assign vld_o = vld_q[LAT-1];
            assign fst_o = fst_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl #(
    parameter int LOG2_MIN  = 11,
    parameter int PROC_MULT = 3,
    parameter int RD_LAT    = 1,
    parameter int DATA_W    = 16,
    localparam int ADDR_W   = LOG2_MIN + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_inv,
    input  logic              in_start,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    input  logic              out_en,
    output logic              loading,
    output logic              busy,
    output logic              res_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_re,
    output logic [DATA_W-1:0] wr_im,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid,
    output logic              out_first,
    output logic [1:0]        xf_size,
    output logic              xf_inv
);
    import xfer_pkg::*;

    localparam int NMIN   = 1 << LOG2_MIN;
    localparam int PCNT_W = $clog2(PROC_MULT * 4 * NMIN);

    localparam logic [ADDR_W-1:0] NL_S = ADDR_W'(NMIN - 1);
    localparam logic [ADDR_W-1:0] NL_M = ADDR_W'(2 * NMIN - 1);
    localparam logic [ADDR_W-1:0] NL_L = ADDR_W'(4 * NMIN - 1);
    localparam logic [PCNT_W-1:0] PL_S = PCNT_W'(PROC_MULT * NMIN - 1);
    localparam logic [PCNT_W-1:0] PL_M = PCNT_W'(PROC_MULT * 2 * NMIN - 1);
    localparam logic [PCNT_W-1:0] PL_L = PCNT_W'(PROC_MULT * 4 * NMIN - 1);

    cfg_regs_t         cfg_d, cfg_q;
    logic [ADDR_W-1:0] n_last;
    logic [PCNT_W-1:0] p_last;
    logic              blk_acc;
    logic              blk_done;
    logic              rd_first;

    always_comb begin
        cfg_d = cfg_q;
        if (clr) begin
            cfg_d.size = (cfg_size == 2'b00) ? 2'b01 : cfg_size;
            cfg_d.inv  = cfg_inv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{size: 2'b01, inv: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        unique case (cfg_q.size)
            2'b10:   begin n_last = NL_M; p_last = PL_M; end
            2'b11:   begin n_last = NL_L; p_last = PL_L; end
            default: begin n_last = NL_S; p_last = PL_S; end
        endcase
    end

    xfer_load #(
        .ADDR_W (ADDR_W),
        .PCNT_W (PCNT_W),
        .DATA_W (DATA_W)
    ) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .start_i   (in_start),
        .re_i      (in_re),
        .im_i      (in_im),
        .n_last_i  (n_last),
        .p_last_i  (p_last),
        .loading_o (loading),
        .busy_o    (busy),
        .accept_o  (blk_acc),
        .done_o    (blk_done),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_re_o   (wr_re),
        .wr_im_o   (wr_im)
    );

    xfer_drain #(
        .ADDR_W (ADDR_W)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .en_i       (out_en),
        .done_i     (blk_done),
        .blk_i      (blk_acc),
        .n_last_i   (n_last),
        .ready_o    (res_ready),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .rd_first_o (rd_first)
    );

    xfer_pipe #(
        .LAT (RD_LAT)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .vld_i (rd_en),
        .fst_i (rd_first),
        .vld_o (out_valid),
        .fst_o (out_first)
    );

    assign xf_size = cfg_q.size;
    assign xf_inv  = cfg_q.inv;

endmodule

// File: rtl/xfer_ctrl_chk.sv
module xfer_ctrl_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              out_en,
    input logic              loading,
    input logic              busy,
    input logic              res_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              out_valid,
    input logic              out_first
);
    p_load_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loading) |-> (wr_en && wr_addr == '0));

    p_load_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> busy);

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> !(wr_en && wr_addr == '0));

    p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ready && out_en && !rd_en && !clr) |=> (!res_ready && rd_en && rd_addr == '0));

    p_first_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !loading && !rd_en && !res_ready));

endmodule

bind xfer_ctrl xfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .out_en    (out_en),
    .loading   (loading),
    .busy      (busy),
    .res_ready (res_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_first (out_first)
);

// File: tb/tb_xfer_ctrl.sv
module tb_xfer_ctrl;
    localparam int LOG2_MIN  = 4;
    localparam int PROC_MULT = 3;
    localparam int RD_LAT    = 1;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = LOG2_MIN + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic [1:0]        cfg_size = 2'b01;
    logic              cfg_inv = 1'b0;
    logic              in_start = 1'b0;
    logic [DATA_W-1:0] in_re = '0;
    logic [DATA_W-1:0] in_im = '0;
    logic              out_en = 1'b0;
    logic              loading, busy, res_ready, wr_en, rd_en, out_valid, out_first, xf_inv;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_re, wr_im;
    logic [1:0]        xf_size;

    xfer_ctrl #(
        .LOG2_MIN  (LOG2_MIN),
        .PROC_MULT (PROC_MULT),
        .RD_LAT    (RD_LAT),
        .DATA_W    (DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_size(cfg_size), .cfg_inv(cfg_inv),
        .in_start(in_start), .in_re(in_re), .in_im(in_im), .out_en(out_en),
        .loading(loading), .busy(busy), .res_ready(res_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid), .out_first(out_first),
        .xf_size(xf_size), .xf_inv(xf_inv)
    );

    always #5 clk = ~clk;

    typedef struct {
        int addr;
        int re;
        int im;
    } wr_item_t;

    int       n_checks = 0;
    int       n_fail = 0;
    int       ncyc = 0;
    wr_item_t wr_q[$];
    int       rd_q[$];
    int       first_q[$];
    wr_item_t w_it;
    int       e_int;
    int       t_lr = 0, t_lf = 0, t_br = 0, t_bf = 0, t_rr = 0, t_rf = 0;
    logic     p_load = 1'b0, p_busy = 1'b0, p_ready = 1'b0, p_rd = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // monitor: scoreboard pops and edge timestamps
    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (rst_n) begin
            if (wr_en) begin
                if (wr_q.size() == 0) begin
                    chk("R2 write with nothing expected, addr", int'(wr_addr), -1);
                end else begin
                    w_it = wr_q.pop_front();
                    chk("R1 write address", int'(wr_addr), w_it.addr);
                    chk("R1 write real", int'(wr_re), w_it.re);
                    chk("R1 write imag", int'(wr_im), w_it.im);
                end
            end
            if (rd_en) begin
                if (rd_q.size() == 0) begin
                    chk("R10 read with nothing expected, addr", int'(rd_addr), -1);
                end else begin
                    e_int = rd_q.pop_front();
                    chk("R5 read address", int'(rd_addr), e_int);
                end
            end
            if (out_valid) begin
                if (first_q.size() == 0) begin
                    chk("R5 output valid with nothing expected", 1, 0);
                end else begin
                    e_int = first_q.pop_front();
                    chk("R5 output first flag", int'(out_first), e_int);
                end
            end
            if (loading && !p_load) t_lr = ncyc;
            if (!loading && p_load) t_lf = ncyc;
            if (busy && !p_busy) t_br = ncyc;
            if (!busy && p_busy) t_bf = ncyc;
            if (res_ready && !p_ready) t_rr = ncyc;
            if (!rd_en && p_rd) t_rf = ncyc;
        end
        p_load  = loading;
        p_busy  = busy;
        p_ready = res_ready;
        p_rd    = rd_en;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_clr(logic [1:0] sz, logic inv);
        tick();
        clr = 1'b1;
        cfg_size = sz;
        cfg_inv = inv;
        tick();
        clr = 1'b0;
    endtask

    function automatic int smp_re(int seed, int i);
        return (seed * 311 + i * 7) & 16'hffff;
    endfunction

    function automatic int smp_im(int seed, int i);
        return (seed * 97 ^ (i * 1013)) & 16'hffff;
    endfunction

    task automatic drive_smp(int seed, int i, bit push);
        wr_item_t it;
        in_re = DATA_W'(smp_re(seed, i));
        in_im = DATA_W'(smp_im(seed, i));
        if (push) begin
            it.addr = i;
            it.re = smp_re(seed, i);
            it.im = smp_im(seed, i);
            wr_q.push_back(it);
        end
    endtask

    task automatic load_block(int n, int seed, int glitch_at);
        tick();
        in_start = 1'b1;
        drive_smp(seed, 0, 1'b1);
        for (int i = 1; i < n; i++) begin
            tick();
            in_start = (i == glitch_at);
            drive_smp(seed, i, 1'b1);
        end
        tick();
        in_start = 1'b0;
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!res_ready && guard < 3000) begin
            tick();
            guard++;
        end
        chk("R4 result became ready", int'(res_ready), 1);
    endtask

    task automatic push_dl(int n);
        for (int i = 0; i < n; i++) begin
            rd_q.push_back(i);
            first_q.push_back(i == 0 ? 1 : 0);
        end
    endtask

    task automatic start_dl(int n);
        push_dl(n);
        tick();
        out_en = 1'b1;
        tick();
        out_en = 1'b0;
        chk("R4 ready drops after enable taken", int'(res_ready), 0);
        chk("R5 read starts cycle after enable", int'(rd_en), 1);
    endtask

    task automatic download(int n);
        start_dl(n);
        tick();
        chk("R5 first sample two cycles after enable", int'(out_valid && out_first), 1);
        repeat (n + 2) tick();
        chk("R5 all reads issued", rd_q.size(), 0);
        chk("R5 all outputs seen", first_q.size(), 0);
        chk("R7 result offered again", int'(res_ready), 1);
        chk("R7 re-offer on cycle reads stop", t_rr, t_rf);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        bit early;
        int guard;
        // reset state
        repeat (3) tick();
        chk("R8 reset flags", int'({loading, busy, res_ready, rd_en, wr_en, out_valid}), 0);
        chk("R8 reset size code", int'(xf_size), 1);
        chk("R8 reset inverse flag", int'(xf_inv), 0);
        rst_n = 1'b1;
        tick();

        // capture on clear
        do_clr(2'b10, 1'b1);
        chk("R8 clear captures size", int'(xf_size), 2);
        chk("R8 clear captures inverse", int'(xf_inv), 1);
        do_clr(2'b01, 1'b0);

        // N=16 with a start pulse in the middle of the load
        load_block(16, 1, 5);
        wait_ready();
        repeat (2) tick();
        chk("R1 loading width", t_lf - t_lr, 15);
        chk("R3 busy width N=16", t_bf - t_br, 63);
        chk("R2 mid-load start kept timing", t_lf - t_lr, 15);
        chk("R4 ready with busy fall", t_rr, t_bf);
        repeat (3) tick();
        download(16);
        download(16);

        // new block during download suppresses the re-offer
        start_dl(16);
        load_block(16, 3, -1);
        tick();
        chk("R7 no re-offer after new block", int'(res_ready), 0);
        chk("R7 new block still busy", int'(busy), 1);
        wait_ready();
        download(16);

        // N=32, start during processing, held enable
        do_clr(2'b10, 1'b1);
        load_block(32, 4, -1);
        repeat (10) tick();
        in_start = 1'b1;
        tick();
        in_start = 1'b0;
        push_dl(32);
        out_en = 1'b1;
        early = 1'b0;
        guard = 0;
        while (!res_ready && guard < 3000) begin
            tick();
            if (rd_en) early = 1'b1;
            guard++;
        end
        chk("R10 no read before ready", int'(early), 0);
        tick();
        chk("R6 held enable starts download", int'(rd_en), 1);
        chk("R6 held enable first address", int'(rd_addr), 0);
        out_en = 1'b0;
        tick();
        chk("R6 first output after auto start", int'(out_valid && out_first), 1);
        repeat (34) tick();
        chk("R6 auto download drained", rd_q.size(), 0);
        chk("R2 processing start ignored, busy width", t_bf - t_br, 127);
        chk("R3 busy width N=32", t_bf - t_br, 127);

        // N=64
        do_clr(2'b11, 1'b0);
        load_block(64, 5, 40);
        wait_ready();
        repeat (2) tick();
        chk("R1 loading width N=64", t_lf - t_lr, 63);
        chk("R3 busy width N=64", t_bf - t_br, 255);
        download(64);

        // reserved size code
        do_clr(2'b00, 1'b0);
        chk("R9 reserved code stored as smallest", int'(xf_size), 1);
        load_block(16, 6, -1);
        wait_ready();
        repeat (2) tick();
        chk("R9 reserved code runs N=16", t_bf - t_br, 63);
        download(16);

        // clear during a load
        tick();
        in_start = 1'b1;
        drive_smp(7, 0, 1'b1);
        tick();
        in_start = 1'b0;
        drive_smp(7, 1, 1'b1);
        tick();
        drive_smp(7, 2, 1'b1);
        tick();
        clr = 1'b1;
        cfg_size = 2'b01;
        cfg_inv = 1'b0;
        tick();
        clr = 1'b0;
        chk("R8 clear aborts load", int'({loading, busy, wr_en}), 0);
        chk("R8 clear drops ready", int'(res_ready), 0);
        repeat (3) tick();
        chk("R1 all writes seen", wr_q.size(), 0);

        finish_run();
    end

endmodule